// File: doc/BRIEF.md
# Serial Register-Access Slave for a Two-Wire Bus

This block sits between a host microcontroller on a two-wire I2C bus and a bank of byte-wide control registers. It watches SDA and SCL and recognises bus conditions: a START (SDA falls while SCL is high), a STOP (SDA rises while SCL is high) and a repeated START. It answers only to the fixed 7-bit device address 1101010. The host then gives a two-byte internal address, and the block moves data bytes between the bus and the register bank through a simple read/write strobe port. SDA and SCL arrive already synchronised to the system clock. The slave drives the line only by pulling it low, through an output-enable.

The internal address holds a register index of up to 1024 entries and a flag that makes the byte pointer advance after every transferred byte. Byte writes, multibyte writes, current-address reads, random reads and sequential reads all go through this one pointer. The register bank returns a per-register "ready" level. When it is low, the slave refuses to acknowledge, so the host learns that the data is not there.

Top module: `i2c_reg_slave`

## Requirements
- R1: A byte of 1101010 followed by the R/W bit (1 = read, 0 = write), sent MSB first, is acknowledged by pulling SDA low during the ninth clock. Any other address byte gets no acknowledge. After a mismatch, further bytes are ignored (no acknowledge, no register strobe) until the next START.
- R2: After reset and after a STOP, the slave leaves SDA released. A repeated START in the middle of a transfer restarts the device-address phase.
- R3: After a write address byte, two internal address bytes follow and each is acknowledged. The first byte carries the auto-increment flag in bit 7 and register index bits 9:8 in bits 1:0. The second byte carries index bits 7:0.
- R4: Each write data byte is stored, with a single-cycle write strobe, at the register that the byte pointer addresses, and is acknowledged.
- R5: The byte pointer advances after each byte read or written only when the auto-increment flag is 1. With the flag at 0 it keeps its value.
- R6: A read returns the register at the byte pointer, MSB first, with each bit changing only while SCL is low. A random read is an address-only write followed by a repeated START with R/W = 1.
- R7: The slave keeps sending consecutive bytes while the host acknowledges. After a host non-acknowledge it releases SDA.
- R8: The byte pointer wraps from 1023 to 0 when it advances.
- R9: A write data byte aimed at a register whose ready input is low is neither acknowledged nor stored. A read address byte is not acknowledged when the register at the pointer is not ready.
- R10: A STOP or START that arrives before the eighth bit of a byte is complete ends that byte without any register write.
- R11: The auto-increment flag from the last address phase stays in force for later current-address reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised serial clock level |
| sda_i | input | 1 | Synchronised serial data level (wired bus value) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr | output | 10 | Register index of the byte pointer |
| reg_rd | output | 1 | One-cycle pulse when a register byte is fetched for output |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Byte to store, valid with reg_wr |
| reg_rdata | input | 8 | Register content at reg_addr |
| reg_avail | input | 1 | Register at reg_addr holds valid data |

## Verification
If the bit counter or the phase register is wrong, SDA shows it within one byte time: an acknowledge lands on the wrong clock, or a read bit appears one position off. If the byte pointer is wrong, nothing shows on the bus straight away. It becomes visible at the next read, which returns the neighbouring register's content. It also becomes visible as a write that lands in the wrong cell, which is why every write sequence is followed by reads and by checks of the register bank at the cells next to the target. An availability decision taken against the wrong address shows up as an acknowledge that should be missing, or the reverse, in that same byte.

// File: rtl/i2c_reg_slave_pkg.sv
package i2c_reg_slave_pkg;

    localparam logic [6:0] DEV_ID    = 7'b1101010;
    localparam int         BYTE_BITS = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEV,
        PH_ADRH,
        PH_ADRL,
        PH_WR,
        PH_RD,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    function automatic logic id_match(input logic [7:0] b, input logic [6:0] id);
        return b[7:1] == id;
    endfunction

endpackage

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond
    import i2c_reg_slave_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        ev.start = scl_i && scl_q && sda_q && !sda_i;
        ev.stop  = scl_i && scl_q && !sda_q && sda_i;
        ev.rise  = scl_i && !scl_q;
        ev.fall  = !scl_i && scl_q;
        ev.sda   = sda_i;
    end

endmodule

// File: rtl/i2c_addr_ctr.sv
module i2c_addr_ctr #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] STEP = 1;

    always_ff @(posedge clk) begin
        if (rst)       addr <= '0;
        else if (load) addr <= load_val;
        else if (inc)  addr <= addr + STEP;
    end

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
    import i2c_reg_slave_pkg::*;
#(
    parameter int         AW       = 10,
    parameter logic [6:0] DEV_ADDR = DEV_ID
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    output logic [AW-1:0] reg_addr,
    output logic          reg_rd,
    output logic          reg_wr,
    output logic [7:0]    reg_wdata,
    input  logic [7:0]    reg_rdata,
    input  logic          reg_avail
);
    localparam int         HW       = AW - 8;
    localparam logic [3:0] LAST_BIT = 4'(BYTE_BITS - 1);
    localparam logic [3:0] FULL     = 4'(BYTE_BITS);
    localparam logic [3:0] ONE      = 4'd1;

    bus_ev_t         ev;
    phase_e          phase;
    phase_e          nxt;
    logic [3:0]      cnt;
    logic [7:0]      sh;
    logic [7:0]      sh_next;
    logic            ack_ph;
    logic            ack_go;
    logic            mack;
    logic            ai;
    logic [HW-1:0]   adr_hi;
    logic            byte_end;
    logic            ctr_load;
    logic            ctr_inc;
    logic            rd_load;
    logic [AW-1:0]   load_val;

    i2c_bus_cond u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_addr_ctr #(.AW(AW)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (ctr_load),
        .load_val (load_val),
        .inc      (ctr_inc),
        .addr     (reg_addr)
    );

    always_comb begin
        sh_next  = {sh[6:0], ev.sda};
        byte_end = ev.rise && !ack_ph && (cnt == LAST_BIT);
        load_val = {adr_hi, sh_next};
        ctr_load = byte_end && (phase == PH_ADRL);
        reg_wr   = byte_end && (phase == PH_WR) && reg_avail;
        reg_wdata = sh_next;
        ctr_inc  = ai && ((ev.fall && ack_ph && (phase == PH_WR) && ack_go)
                       || (ev.rise && ack_ph && (phase == PH_RD)));
        rd_load  = ev.fall && ack_ph &&
                   (((phase == PH_DEV) && ack_go && (nxt == PH_RD))
                    || ((phase == PH_RD) && mack));
        reg_rd   = rd_load;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            nxt    <= PH_IDLE;
            cnt    <= '0;
            sh     <= '0;
            ack_ph <= 1'b0;
            ack_go <= 1'b0;
            mack   <= 1'b0;
            ai     <= 1'b0;
            adr_hi <= '0;
            sda_oe <= 1'b0;
        end else if (ev.start) begin
            phase  <= PH_DEV;
            cnt    <= '0;
            ack_ph <= 1'b0;
            sda_oe <= 1'b0;
        end else if (ev.stop) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            ack_ph <= 1'b0;
            sda_oe <= 1'b0;
        end else begin
            unique case (phase)
                PH_DEV, PH_ADRH, PH_ADRL, PH_WR: begin
                    if (ev.rise && !ack_ph) begin
                        sh  <= sh_next;
                        cnt <= cnt + ONE;
                        if (cnt == LAST_BIT) begin
                            unique case (phase)
                                PH_DEV: begin
                                    if (!id_match(sh_next, DEV_ADDR)) begin
                                        ack_go <= 1'b0;
                                        nxt    <= PH_SKIP;
                                    end else if (sh_next[0]) begin
                                        ack_go <= reg_avail;
                                        nxt    <= PH_RD;
                                    end else begin
                                        ack_go <= 1'b1;
                                        nxt    <= PH_ADRH;
                                    end
                                end
                                PH_ADRH: begin
                                    ack_go <= 1'b1;
                                    ai     <= sh_next[7];
                                    adr_hi <= sh_next[HW-1:0];
                                    nxt    <= PH_ADRL;
                                end
                                PH_ADRL: begin
                                    ack_go <= 1'b1;
                                    nxt    <= PH_WR;
                                end
                                default: begin
                                    ack_go <= reg_avail;
                                    nxt    <= PH_WR;
                                end
                            endcase
                        end
                    end else if (ev.fall && !ack_ph && (cnt == FULL)) begin
                        ack_ph <= 1'b1;
                        sda_oe <= ack_go;
                    end else if (ev.fall && ack_ph) begin
                        ack_ph <= 1'b0;
                        cnt    <= '0;
                        phase  <= ack_go ? nxt : PH_SKIP;
                        if (rd_load) begin
                            sh     <= reg_rdata;
                            sda_oe <= ~reg_rdata[7];
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                end
                PH_RD: begin
                    if (ev.rise && !ack_ph) begin
                        cnt <= cnt + ONE;
                    end else if (ev.rise && ack_ph) begin
                        mack <= !ev.sda;
                    end else if (ev.fall && !ack_ph) begin
                        if (cnt == FULL) begin
                            sda_oe <= 1'b0;
                            ack_ph <= 1'b1;
                        end else begin
                            sh     <= {sh[6:0], 1'b0};
                            sda_oe <= ~sh[6];
                        end
                    end else if (ev.fall && ack_ph) begin
                        ack_ph <= 1'b0;
                        cnt    <= '0;
                        if (mack) begin
                            sh     <= reg_rdata;
                            sda_oe <= ~reg_rdata[7];
                        end else begin
                            sda_oe <= 1'b0;
                            phase  <= PH_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          scl_i,
    input logic          sda_oe,
    input logic          reg_wr,
    input logic          reg_avail,
    input logic [AW-1:0] reg_addr,
    input logic          ev_start,
    input logic          ev_stop,
    input logic          ctr_inc,
    input logic          ctr_load
);
    localparam logic [AW-1:0] ONE = 1;

    // R4: every write strobe lasts exactly one cycle
    assert_wr_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> !reg_wr);

    // R9: no write reaches a register that is not ready
    assert_wr_ready_R9: assert property (@(posedge clk) disable iff (rst)
        reg_wr |-> reg_avail);

    // R2: a STOP leaves the line released
    assert_stop_release_R2: assert property (@(posedge clk) disable iff (rst)
        ev_stop |=> !sda_oe);

    // R6: the slave changes its drive only after SCL went low
    assert_drive_scl_low_R6: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sda_oe) && !$past(ev_start) && !$past(ev_stop)) |-> !$past(scl_i));

    // R8: an advance moves the pointer by exactly one, modulo the bank size
    assert_ptr_step_R8: assert property (@(posedge clk) disable iff (rst)
        (ctr_inc && !ctr_load) |=> ((reg_addr - $past(reg_addr)) == ONE));

    // R5: without load or advance the pointer holds
    assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!ctr_inc && !ctr_load) |=> $stable(reg_addr));

endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .reg_wr    (reg_wr),
    .reg_avail (reg_avail),
    .reg_addr  (reg_addr),
    .ev_start  (ev.start),
    .ev_stop   (ev.stop),
    .ctr_inc   (ctr_inc),
    .ctr_load  (ctr_load)
);

// File: tb/i2c_reg_slave_bench.sv
module i2c_reg_slave_bench;
    localparam int         CLK_PERIOD = 10;
    localparam int         Q          = 4;
    localparam logic [6:0] DEV        = 7'b1101010;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_low = 1'b0;
    logic       sda_bus;
    logic       sda_oe;
    logic [9:0] reg_addr;
    logic       reg_rd;
    logic       reg_wr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       reg_avail;

    logic [7:0] mem     [1024];
    logic [7:0] exp_mem [1024];
    logic       avail_m [1024];
    logic [9:0] exp_ctr = '0;
    logic       exp_ai  = 1'b0;
    int         checks  = 0;
    int         errors  = 0;
    int         wr_count = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_bus   = !(m_low || sda_oe);
    assign reg_rdata = mem[reg_addr];
    assign reg_avail = avail_m[reg_addr];

    always @(posedge clk) begin
        if (reg_wr) begin
            mem[reg_addr] <= reg_wdata;
            wr_count <= wr_count + 1;
        end
    end

    i2c_reg_slave u_i2c_reg_slave (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (m_scl),
        .sda_i     (sda_bus),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .reg_avail (reg_avail)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_low = 1'b1; tick(Q);
        m_scl = 1'b0; tick(1);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_low = 1'b0; tick(Q);
    endtask

    task automatic bit_out(input logic b);
        m_low = !b;  tick(Q);
        m_scl = 1'b1; tick(Q);
        m_scl = 1'b0; tick(1);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        m_low = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q/2);
        ack = !sda_bus; tick(Q/2);
        m_scl = 1'b0; tick(1);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        m_low = 1'b0;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            tick(Q);
            m_scl = 1'b1; tick(Q/2);
            d = {d[6:0], sda_bus}; tick(Q/2);
            m_scl = 1'b0; tick(1);
        end
        m_low = give_ack; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_scl = 1'b0; tick(1);
        m_low = 1'b0;
    endtask

    task automatic send_addr(input logic [9:0] a, input logic ai, input string rq);
        logic ak;
        send_byte({ai, 5'b0, a[9:8]}, ak); chk(rq, ak, 1'b1);
        send_byte(a[7:0], ak);             chk(rq, ak, 1'b1);
        exp_ctr = a;
        exp_ai  = ai;
    endtask

    task automatic do_write(input logic [9:0] a, input logic ai, input int n,
                            input logic [7:0] dat [4], input string rq);
        logic ak;
        logic ex;
        bus_start();
        send_byte({DEV, 1'b0}, ak); chk("R1", ak, 1'b1);
        send_addr(a, ai, "R3");
        for (int i = 0; i < n; i++) begin
            ex = avail_m[exp_ctr];
            send_byte(dat[i], ak);
            chk(rq, ak, ex);
            if (!ex) break;
            exp_mem[exp_ctr] = dat[i];
            if (exp_ai) exp_ctr = exp_ctr + 10'd1;
        end
        bus_stop();
    endtask

    task automatic do_read(input logic random, input logic [9:0] a, input logic ai,
                           input int n, input string rq);
        logic       ak;
        logic [7:0] d;
        bus_start();
        if (random) begin
            send_byte({DEV, 1'b0}, ak); chk("R6", ak, 1'b1);
            send_addr(a, ai, "R6");
            bus_start();
        end
        send_byte({DEV, 1'b1}, ak);
        chk(rq, ak, avail_m[exp_ctr]);
        if (!ak) begin
            bus_stop();
            return;
        end
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, d);
            chk(rq, d, exp_mem[exp_ctr]);
            if (exp_ai) exp_ctr = exp_ctr + 10'd1;
        end
        chk("R7", sda_oe, 1'b0);
        bus_stop();
    endtask

    initial begin
        logic       ak;
        logic [7:0] d;
        logic [7:0] buf4 [4];
        int         wc;
        int unsigned seed;
        seed = $urandom(32'h5EED_1234);
        for (int i = 0; i < 1024; i++) begin
            mem[i]     = 8'(i * 7 + 3);
            exp_mem[i] = 8'(i * 7 + 3);
            avail_m[i] = 1'b1;
        end
        avail_m[700] = 1'b0;

        tick(5);
        rst = 1'b0;
        tick(2);
        // R2: released line after reset
        chk("R2", sda_oe, 1'b0);
        chk("R4", reg_wr, 1'b0);

        // R1: foreign address ignored, and a matching byte without START too
        wc = wr_count;
        bus_start();
        send_byte(8'hAA, ak);       chk("R1", ak, 1'b0);
        send_byte({DEV, 1'b0}, ak); chk("R1", ak, 1'b0);
        send_byte(8'h00, ak);       chk("R1", ak, 1'b0);
        bus_stop();
        chk("R1", wr_count, wc);

        // R4 R5: two bytes without auto-increment land in the same cell
        buf4 = '{8'hA5, 8'h5A, 8'h00, 8'h00};
        do_write(10'd5, 1'b0, 2, buf4, "R4");
        chk("R4", mem[5], 8'h5A);
        chk("R5", mem[6], exp_mem[6]);
        do_read(1'b0, 10'd0, 1'b0, 2, "R5");

        // R8: multibyte write across the top of the bank
        buf4 = '{8'h11, 8'h22, 8'h33, 8'h44};
        do_write(10'h3FE, 1'b1, 4, buf4, "R4");
        chk("R8", mem[0], 8'h33);
        chk("R8", mem[1], 8'h44);
        do_read(1'b1, 10'h3FE, 1'b1, 4, "R8");

        // R11: flag persists for a current-address read (pointer now 2)
        chk("R11", exp_ctr, 10'd2);
        do_read(1'b0, 10'd0, 1'b0, 2, "R11");

        // R9: not-ready register refuses a write, then refuses a read
        buf4 = '{8'hC3, 8'h3C, 8'h00, 8'h00};
        do_write(10'd699, 1'b1, 2, buf4, "R9");
        chk("R9", mem[700], exp_mem[700]);
        chk("R9", mem[699], 8'hC3);
        do_read(1'b0, 10'd0, 1'b0, 1, "R9");

        // R10: STOP in the middle of a data byte
        wc = wr_count;
        bus_start();
        send_byte({DEV, 1'b0}, ak); chk("R1", ak, 1'b1);
        send_addr(10'd10, 1'b1, "R3");
        for (int i = 0; i < 4; i++) bit_out(1'b1);
        bus_stop();
        chk("R10", wr_count, wc);
        chk("R10", mem[10], exp_mem[10]);

        // R10 R2: repeated START mid-byte restarts the address phase
        bus_start();
        send_byte({DEV, 1'b0}, ak); chk("R1", ak, 1'b1);
        send_addr(10'd12, 1'b1, "R3");
        for (int i = 0; i < 3; i++) bit_out(1'b0);
        bus_start();
        send_byte({DEV, 1'b1}, ak); chk("R2", ak, 1'b1);
        recv_byte(1'b0, d);
        chk("R6", d, exp_mem[12]);
        exp_ctr = exp_ctr + 10'd1;
        bus_stop();
        chk("R10", wr_count, wc);

        // R4 R6 R7: random transfers
        for (int it = 0; it < 30; it++) begin
            logic [9:0] a;
            logic       ai;
            int         n;
            a  = 10'($urandom % 1024);
            ai = 1'($urandom % 2);
            n  = 1 + int'($urandom % 4);
            for (int k = 0; k < 4; k++) buf4[k] = 8'($urandom);
            do_write(a, ai, n, buf4, "R4");
            do_read(1'b1, a, ai, n, "R6");
        end

        // R5 R8: whole-bank sample against the model
        for (int i = 0; i < 1024; i += 97) chk("R4", mem[i], exp_mem[i]);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule